// File: doc/BRIEF.md
# Zoned Data Memory Wait-State Controller

This block connects the data-memory port of a processor core to an external asynchronous memory bus. The core presents a 14-bit word address, a read/write flag and 16-bit write data. The block decodes the address into one of five regions: three external zones, the on-chip data RAM, or the region that holds the memory-mapped control registers. Only the three external zones start a cycle on the external bus.

For an external access the block drives a chip select and a read or write strobe. It keeps the access open for the number of wait states programmed for that zone, plus one cycle. It then gives the core a one-cycle completion pulse. Write data goes out on the upper sixteen lines of a 24-bit bidirectional bus, and read data is taken from those same lines. Accesses to the on-chip regions raise no bus activity and complete after one cycle.

A configuration register holds one 3-bit wait-state field per zone. It also holds two spare fields, which are stored but act on nothing. While an access is open, a busy flag tells the core to hold off further requests.

Top module: `zdm_wait_ctrl`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are 0 and `ext_dms_n`, `ext_rd_n` and `ext_wr_n` are 1. `cfg_rdata` reads 15'h7FFF, meaning every field holds 7 wait states.
- R2: A request to an address from 0x0000 to 0x2FFF opens an external cycle: `ext_dms_n` goes low and `ext_addr` equals the request address. The wait-state field used depends on the address: zone 0 covers 0x0000–0x03FF, zone 1 covers 0x0400–0x07FF and zone 2 covers 0x0800–0x2FFF.
- R3: A request to an address from 0x3000 to 0x3FFF opens no external cycle. This covers both the on-chip RAM and the control-register region. `ext_dms_n`, `ext_rd_n` and `ext_wr_n` stay 1, and `done` pulses in the cycle after acceptance.
- R4: An external access using a field value N holds the select, the active strobe and `ext_addr` for exactly N+1 cycles. These cycles begin in the cycle after the request is accepted.
- R5: `done` is high for exactly one cycle, which is the last cycle of the held strobes. The select and the strobes are released in the following cycle.
- R6: `busy` is high from the cycle after acceptance through the `done` cycle. A request is accepted only in a cycle where `busy` is 0, and a request presented while `busy` is 1 is ignored.
- R7: `cfg_rdata` bits [3k+2:3k] hold field k. Fields 0 to 2 set the wait states of zones 0 to 2. Fields 3 and 4 can be written and read back but change no access timing.
- R8: A write to the configuration register takes effect only for accesses accepted in a later cycle. An access already open, or accepted in the same cycle as the write, keeps its old count.
- R9: During an external write, `ext_data[23:8]` carries the request write data while `ext_wr_n` is 0. The block drives `ext_data` only while `ext_wr_n` is 0, and it never drives `ext_data[7:0]`.
- R10: For an external read, `rdata` takes the value of `ext_data[23:8]` sampled in the `done` cycle. The new value is visible from the next cycle until the next external read completes.
- R11: `ext_rd_n` goes low only for reads and `ext_wr_n` only for writes. The two are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | An access is open; new requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data from the last external read |
| cfg_we | input | 1 | Write enable of the wait-state register |
| cfg_wdata | input | 15 | New wait-state register value |
| cfg_rdata | output | 15 | Current wait-state register value |
| ext_addr | output | 14 | External address |
| ext_dms_n | output | 1 | Active-low data memory select |
| ext_rd_n | output | 1 | Active-low read strobe / output enable |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_data | inout | 24 | External data bus; upper 16 lines carry data |

## Verification
Reads and writes are made at both edges of every zone and of the two on-chip regions. Run at the reset counts and again at small mixed counts, these accesses show that each address reaches the right field and that no on-chip address reaches the bus. A dense stream of back-to-back requests, with addresses and directions that keep changing, separates requests that were correctly ignored while busy from requests that were wrongly accepted. Configuration writes arrive at random points in that stream, including the acceptance cycle and the middle of an access. These writes show whether a new count can leak into an access that is already open, and whether the spare fields touch the timing.

// File: rtl/zdm_pkg.sv
package zdm_pkg;
    localparam int ADDR_W     = 14;
    localparam int DATA_W     = 16;
    localparam int BUS_W      = 24;
    localparam int WS_W       = 3;
    localparam int NUM_FIELDS = 5;
    localparam int NUM_ZONES  = 3;
    localparam int CFG_W      = WS_W * NUM_FIELDS;
    localparam int IDX_W      = $clog2(NUM_FIELDS);
    localparam int LANE_LO    = BUS_W - DATA_W;

    localparam logic [ADDR_W-1:0] ZONE1_BASE = 14'h0400;
    localparam logic [ADDR_W-1:0] ZONE2_BASE = 14'h0800;
    localparam logic [ADDR_W-1:0] RAM_BASE   = 14'h3000;
    localparam logic [ADDR_W-1:0] REGS_BASE  = 14'h3800;

    typedef enum logic [2:0] {
        RGN_ZONE0, RGN_ZONE1, RGN_ZONE2, RGN_RAM, RGN_REGS
    } region_e;

    typedef enum logic [1:0] {
        SQ_IDLE, SQ_EXT, SQ_LOCAL
    } seq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } access_s;

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        if (a >= REGS_BASE)       return RGN_REGS;
        else if (a >= RAM_BASE)   return RGN_RAM;
        else if (a >= ZONE2_BASE) return RGN_ZONE2;
        else if (a >= ZONE1_BASE) return RGN_ZONE1;
        else                      return RGN_ZONE0;
    endfunction
endpackage

// File: rtl/zdm_decode.sv
module zdm_decode
    import zdm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              external,
    output logic [IDX_W-1:0]  zone_idx
);
    region_e rgn;

    always_comb begin
        rgn      = classify(addr);
        external = 1'b0;
        zone_idx = '0;
        case (rgn)
            RGN_ZONE0: begin external = 1'b1; zone_idx = IDX_W'(0); end
            RGN_ZONE1: begin external = 1'b1; zone_idx = IDX_W'(1); end
            RGN_ZONE2: begin external = 1'b1; zone_idx = IDX_W'(2); end
            default:   begin external = 1'b0; zone_idx = '0; end
        endcase
    end

    always_comb begin
        AST_LOCAL_NOT_EXT: assert (!(external && addr >= RAM_BASE)); // R3
        AST_ZONE_RANGE: assert (!external || zone_idx < IDX_W'(NUM_ZONES)); // R2
    end
endmodule

// File: rtl/zdm_wait_regs.sv
module zdm_wait_regs
    import zdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0] zone_idx,
    output logic [CFG_W-1:0] cfg_q,
    output logic [WS_W-1:0]  ws
);
    logic [WS_W-1:0] field_q [NUM_FIELDS];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)
                field_q[g] <= '1;
            else if (cfg_we)
                field_q[g] <= cfg_wdata[g*WS_W +: WS_W];
        end
        assign cfg_q[g*WS_W +: WS_W] = field_q[g];
    end

    always_comb begin
        ws = '0;
        for (int z = 0; z < NUM_ZONES; z++)
            if (zone_idx == IDX_W'(z)) ws = field_q[z];
    end

    AST_RESET_MAX: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !$past(cfg_we)) |-> (cfg_q == '1)); // R1
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we)) |-> $stable(cfg_q)); // R7
endmodule

// File: rtl/zdm_seq.sv
module zdm_seq
    import zdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  access_s           req,
    input  logic              external,
    input  logic [WS_W-1:0]   ws,
    input  logic [DATA_W-1:0] bus_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              dms_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_data
);
    seq_e              state_q;
    logic [WS_W-1:0]   cnt_q;
    access_s           acc_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            acc_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (req_valid) begin
                    acc_q <= req;
                    if (external) begin
                        state_q <= SQ_EXT;
                        cnt_q   <= ws;
                    end else begin
                        state_q <= SQ_LOCAL;
                    end
                end
                SQ_EXT: begin
                    if (cnt_q == '0) begin
                        state_q <= SQ_IDLE;
                        if (!acc_q.write) rdata_q <= bus_in;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SQ_LOCAL: state_q <= SQ_IDLE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state_q != SQ_IDLE);
        done     = (state_q == SQ_LOCAL) || (state_q == SQ_EXT && cnt_q == '0);
        dms_n    = !(state_q == SQ_EXT);
        rd_n     = !(state_q == SQ_EXT && !acc_q.write);
        wr_n     = !(state_q == SQ_EXT && acc_q.write);
        drv_en   = !wr_n;
        drv_data = acc_q.wdata;
        bus_addr = acc_q.addr;
        rdata    = rdata_q;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R11
    AST_STROBE_SEL: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !dms_n); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!dms_n && !$past(dms_n) && !$past(done)) |-> ($stable(bus_addr) && $stable(rd_n))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (done && !dms_n) |=> (dms_n && rd_n && wr_n)); // R5
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R6
    AST_DRIVE_WR: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (!wr_n && !dms_n)); // R9
endmodule

// File: rtl/zdm_wait_ctrl.sv
module zdm_wait_ctrl
    import zdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_dms_n,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    inout  wire  [BUS_W-1:0]  ext_data
);
    logic              external;
    logic [IDX_W-1:0]  zone_idx;
    logic [WS_W-1:0]   ws;
    logic              drv_en;
    logic [DATA_W-1:0] drv_data;
    access_s           req;

    assign req = '{addr: req_addr, write: req_write, wdata: req_wdata};

    zdm_decode u_decode (
        .addr     (req_addr),
        .external (external),
        .zone_idx (zone_idx)
    );

    zdm_wait_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .zone_idx  (zone_idx),
        .cfg_q     (cfg_rdata),
        .ws        (ws)
    );

    zdm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .external  (external),
        .ws        (ws),
        .bus_in    (ext_data[BUS_W-1:LANE_LO]),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .bus_addr  (ext_addr),
        .dms_n     (ext_dms_n),
        .rd_n      (ext_rd_n),
        .wr_n      (ext_wr_n),
        .drv_en    (drv_en),
        .drv_data  (drv_data)
    );

    assign ext_data[BUS_W-1:LANE_LO] = drv_en ? drv_data : {DATA_W{1'bz}};
    assign ext_data[LANE_LO-1:0]     = {LANE_LO{1'bz}};
endmodule

// File: tb/zdm_wait_ctrl_tb_top.sv
module zdm_wait_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        cfg_we = 1'b0;
    logic [14:0] cfg_wdata = '0;
    logic        busy, done;
    logic [15:0] rdata;
    logic [14:0] cfg_rdata;
    logic [13:0] ext_addr;
    logic        ext_dms_n, ext_rd_n, ext_wr_n;
    wire  [23:0] ext_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    function automatic logic [15:0] pat(input logic [13:0] a);
        return {2'b10, a} ^ 16'h5A5A;
    endfunction

    // memory model: drives the data lines while the read strobe is low
    assign ext_data[23:8] = (!ext_rd_n) ? pat(ext_addr) : 16'hzzzz;

    zdm_wait_ctrl dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ext_addr(ext_addr), .ext_dms_n(ext_dms_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_data(ext_data)
    );

    // reference model: 0 idle, 1 external, 2 local
    int          m_state = 0;
    int          m_rem = 0;
    bit          m_we = 0;
    logic [13:0] m_addr = '0;
    logic [15:0] m_wdata = '0;
    logic [14:0] m_cfg = 15'h7FFF;
    logic [15:0] m_rdata = '0;

    function automatic int zone_of(input logic [13:0] a);
        if (int'(a) < 1024) return 0;
        if (int'(a) < 2048) return 1;
        if (int'(a) < 12288) return 2;
        return -1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            m_state = 0; m_rem = 0; m_we = 0; m_addr = '0; m_wdata = '0;
            m_cfg = 15'h7FFF; m_rdata = '0;
        end else begin
            if (m_state == 0) begin
                if (req_valid) begin
                    m_addr = req_addr; m_we = req_write; m_wdata = req_wdata;
                    if (zone_of(req_addr) >= 0) begin
                        m_state = 1;
                        m_rem = int'((m_cfg >> (3 * zone_of(req_addr))) & 15'h7);
                    end else begin
                        m_state = 2;
                    end
                end
            end else if (m_state == 2) begin
                m_state = 0;
            end else if (m_rem == 0) begin
                if (!m_we) m_rdata = pat(m_addr);
                m_state = 0;
            end else begin
                m_rem--;
            end
            if (cfg_we) m_cfg = cfg_wdata;
        end
        if (cyc >= 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            automatic bit ext  = (m_state == 1);
            automatic bit fin  = (m_state == 2) || (ext && m_rem == 0);
            chk("R6 busy", 32'(busy), 32'(m_state != 0));
            chk("R5 done", 32'(done), 32'(fin));
            chk("R4 select", 32'(ext_dms_n), 32'(!ext));
            chk("R11 read strobe", 32'(ext_rd_n), 32'(!(ext && !m_we)));
            chk("R11 write strobe", 32'(ext_wr_n), 32'(!(ext && m_we)));
            chk("R7 cfg readback", 32'(cfg_rdata), 32'(m_cfg));
            chk("R10 rdata", 32'(rdata), 32'(m_rdata));
            if (ext) chk("R2 address", 32'(ext_addr), 32'(m_addr));
            if (ext && m_we) chk("R9 write data", 32'(ext_data[23:8]), 32'(m_wdata));
        end
    end

    task automatic access(input logic [13:0] a, input bit w, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (m_state != 0) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [14:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 cfg reset", 32'(cfg_rdata), 32'h7FFF);
        chk("R1 select idle", 32'(ext_dms_n), 32'd1);
        chk("R1 busy idle", 32'(busy), 32'd0);
        rst = 1'b0;
        // R2 R4: default counts, zone edges
        access(14'h0000, 0, 16'h0);
        access(14'h2FFF, 1, 16'hBEEF);
        access(14'h07FF, 0, 16'h0);
        // R3: on-chip regions
        access(14'h3000, 0, 16'h0);
        access(14'h37FF, 1, 16'h1111);
        access(14'h3800, 1, 16'h2222);
        access(14'h3FFF, 0, 16'h0);
        // R7: mixed counts, spare fields set
        set_cfg({3'd1, 3'd7, 3'd5, 3'd3, 3'd0});
        access(14'h03FF, 0, 16'h0);
        access(14'h0400, 1, 16'hC0DE);
        access(14'h0800, 0, 16'h0);
        access(14'h2FFF, 1, 16'hFACE);
        set_cfg({3'd6, 3'd2, 3'd0, 3'd0, 3'd0});
        access(14'h0123, 0, 16'h0);
        access(14'h1000, 0, 16'h0);
        // R8: config write in acceptance cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 14'h0010;
        cfg_we = 1'b1; cfg_wdata = 15'h7FFF;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        while (m_state != 0) @(negedge clk);
        access(14'h0010, 1, 16'h5555);
        // R6 R8: dense stream with config writes mid-access
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            req_valid = (i % 3) != 0;
            req_write = i[0];
            req_addr  = 14'((i * 877) % 16384);
            req_wdata = 16'(i * 16'h1357);
            cfg_we    = (i % 17) == 5;
            cfg_wdata = 15'((i * 4111) & 32'h7FFF);
        end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        while (m_state != 0) @(negedge clk);
        // R1: reset mid-access returns to idle defaults
        set_cfg(15'h0000);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h0200;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset abort", 32'(ext_dms_n), 32'd1);
        chk("R1 cfg restored", 32'(cfg_rdata), 32'h7FFF);
        rst = 1'b0;
        access(14'h0001, 0, 16'h0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule